// File: doc/BRIEF.md
# Folded Symmetric FIR Filter

This block is a fixed-coefficient FIR filter whose impulse response is either mirror-symmetric or mirror-antisymmetric. Before multiplication it combines each pair of taps that share a coefficient magnitude. In sum mode the pair is added and in difference mode it is subtracted. This leaves one multiplier per pair, plus one for the centre tap when the tap count is odd. Only the first half of the coefficient set is given at compile time. The mirrored half follows from the mode.

The filter is built to sit on a system clock that runs far faster than its sample rate. A one-cycle sample strobe accompanies every new input. Every register in the filter moves only on that strobe, so idle gaps of any length between samples leave the result untouched. The datapath has three register stages: pre-add, multiply and accumulate. Internal words are sized so that no intermediate or final sum can wrap. The output carries full precision and has a one-cycle valid pulse.

Top module: `symfir_top`

## Requirements
- R1: In sum mode (`MODE = FOLD_SUM`) the full response is h[N-1-k] = h[k]. The half-set is packed with h[k] at `COEFS[k*CW +: CW]` for k < ceil(N/2), as signed two's complement. The output equals sum over k of h[k]*x[n-k], with the newest sample as x[n].
- R2: In difference mode (`MODE = FOLD_DIFF`) the full response is h[N-1-k] = -h[k]. When N is odd the centre coefficient is taken as zero, whatever its packed value.
- R3: A single sample of value 1 followed by zeros produces the full coefficient sequence h[0], h[1], ..., h[N-1] on consecutive valid outputs.
- R4: Without `smp_en`, `y_out` keeps its value and `y_valid` stays low. An idle gap between strobes does not change any later result.
- R5: `y_valid` is high for the single clock cycle after the third strobe following reset, and after every later strobe. The `y_out` shown in that cycle belongs to the sample presented two strobes earlier.
- R6: `y_out` is DW+CW+ceil(log2(N))+1 bits wide, and results are exact for every input, including runs of the most negative and most positive values.
- R7: Synchronous active-high `rst` clears `y_out` to 0 and `y_valid` to 0. It also clears the sample history, so results after reset are computed as if all earlier samples were zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_en | input | 1 | One-cycle strobe that marks a new sample and advances the filter |
| smp_in | input | DW | Signed input sample |
| y_out | output | DW+CW+ceil(log2(TAPS))+1 | Signed full-precision filter output |
| y_valid | output | 1 | One-cycle pulse when `y_out` holds a new result |

## Verification
The case hardest to reach from the ports is the worst-case magnitude in the accumulator. Reaching it needs coefficients at the signed extremes and long runs of extreme input samples whose signs line up with those coefficients. The bench therefore uses coefficient sets containing -128 and 127 and feeds runs of -128 and 127 through them. It also sweeps every 8-bit input value, with irregular idle gaps between strobes. Three instances run side by side: sum mode with odd N, difference mode with even N, and difference mode with odd N, where the nonzero packed centre coefficient must have no effect.

// File: rtl/symfir_pkg.sv
package symfir_pkg;

  typedef enum logic {
    FOLD_SUM  = 1'b0,
    FOLD_DIFF = 1'b1
  } fold_mode_e;

  function automatic int acc_width(input int dw, input int cw, input int taps);
    return dw + cw + $clog2(taps) + 1;
  endfunction

endpackage

// File: rtl/symfir_delay.sv
module symfir_delay #(
  parameter int DW   = 8,
  parameter int TAPS = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [DW-1:0]        din,
  output logic [TAPS*DW-1:0]   taps_flat
);

  localparam int DEPTH = TAPS - 1;

  logic [DW-1:0] sr [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
    end else if (en) begin
      sr[0] <= din;
      for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
    end
  end

  assign taps_flat[DW-1:0] = din;
  for (genvar i = 1; i < TAPS; i++) begin : g_tap
    assign taps_flat[i*DW +: DW] = sr[i-1];
  end

endmodule

// File: rtl/symfir_fold.sv
module symfir_fold
  import symfir_pkg::*;
#(
  parameter int         DW   = 8,
  parameter int         TAPS = 5,
  parameter fold_mode_e MODE = FOLD_SUM,
  localparam int        HALF = (TAPS + 1) / 2,
  localparam int        PW   = DW + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic [TAPS*DW-1:0]   taps_flat,
  output logic [HALF*PW-1:0]   pre_flat
);

  for (genvar k = 0; k < HALF; k++) begin : g_pair
    logic [DW-1:0]        a;
    logic [DW-1:0]        b;
    logic signed [PW-1:0] s;
    logic signed [PW-1:0] pre_q;

    assign a = taps_flat[k*DW +: DW];
    assign b = taps_flat[(TAPS-1-k)*DW +: DW];

    if (2*k + 1 == TAPS) begin : g_mid
      if (MODE == FOLD_DIFF) begin : g_zero
        assign s = '0;
      end else begin : g_pass
        assign s = $signed({a[DW-1], a});
      end
    end else if (MODE == FOLD_DIFF) begin : g_sub
      assign s = $signed({a[DW-1], a}) - $signed({b[DW-1], b});
    end else begin : g_add
      assign s = $signed({a[DW-1], a}) + $signed({b[DW-1], b});
    end

    always_ff @(posedge clk) begin
      if (rst)     pre_q <= '0;
      else if (en) pre_q <= s;
    end

    assign pre_flat[k*PW +: PW] = pre_q;
  end

endmodule

// File: rtl/symfir_mac.sv
module symfir_mac #(
  parameter int DW    = 8,
  parameter int CW    = 8,
  parameter int HALF  = 3,
  parameter int ACC_W = 20,
  parameter logic [HALF*CW-1:0] COEFS = '0,
  localparam int PW = DW + 1,
  localparam int MW = PW + CW
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [HALF*PW-1:0]      pre_flat,
  output logic signed [ACC_W-1:0] acc_q
);

  function automatic longint bound_f();
    longint b;
    b = 0;
    for (int k = 0; k < HALF; k++) begin
      longint c;
      c = longint'($signed(COEFS[k*CW +: CW]));
      b += (c < 0) ? -c : c;
    end
    return b * (longint'(1) << DW);
  endfunction

  localparam longint BOUND = bound_f();

  logic signed [ACC_W-1:0] ext [HALF];
  logic signed [ACC_W-1:0] sum;

  for (genvar k = 0; k < HALF; k++) begin : g_mul
    localparam logic signed [CW-1:0] H = COEFS[k*CW +: CW];
    logic signed [PW-1:0] p;
    logic signed [MW-1:0] prod_q;

    assign p = $signed(pre_flat[k*PW +: PW]);

    always_ff @(posedge clk) begin
      if (rst)     prod_q <= '0;
      else if (en) prod_q <= p * H;
    end

    assign ext[k] = $signed({{(ACC_W-MW){prod_q[MW-1]}}, prod_q});
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < HALF; k++) sum = sum + ext[k];
  end

  always_ff @(posedge clk) begin
    if (rst)     acc_q <= '0;
    else if (en) acc_q <= sum;
  end

  // R6: the accumulated result never leaves the range the coefficient set allows
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (acc_q >= -BOUND) && (acc_q <= BOUND));

endmodule

// File: rtl/symfir_top.sv
module symfir_top
  import symfir_pkg::*;
#(
  parameter int         DW   = 8,
  parameter int         CW   = 8,
  parameter int         TAPS = 5,
  parameter fold_mode_e MODE = FOLD_SUM,
  parameter logic [((TAPS+1)/2)*CW-1:0] COEFS = {8'h09, 8'h7F, 8'h80},
  localparam int        ACC_W = acc_width(DW, CW, TAPS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    smp_en,
  input  logic [DW-1:0]           smp_in,
  output logic signed [ACC_W-1:0] y_out,
  output logic                    y_valid
);

  localparam int HALF = (TAPS + 1) / 2;
  localparam int PW   = DW + 1;

  logic [TAPS*DW-1:0] taps_flat;
  logic [HALF*PW-1:0] pre_flat;
  logic               v_pre;
  logic               v_mul;

  symfir_delay #(.DW(DW), .TAPS(TAPS)) u_delay (
    .clk(clk), .rst(rst), .en(smp_en), .din(smp_in), .taps_flat(taps_flat)
  );

  symfir_fold #(.DW(DW), .TAPS(TAPS), .MODE(MODE)) u_fold (
    .clk(clk), .rst(rst), .en(smp_en), .taps_flat(taps_flat), .pre_flat(pre_flat)
  );

  symfir_mac #(.DW(DW), .CW(CW), .HALF(HALF), .ACC_W(ACC_W), .COEFS(COEFS)) u_mac (
    .clk(clk), .rst(rst), .en(smp_en), .pre_flat(pre_flat), .acc_q(y_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v_pre   <= 1'b0;
      v_mul   <= 1'b0;
      y_valid <= 1'b0;
    end else begin
      y_valid <= smp_en & v_mul;
      if (smp_en) begin
        v_pre <= 1'b1;
        v_mul <= v_pre;
      end
    end
  end

  // R7: the cycle after reset shows a cleared output
  a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (y_out == '0) && !y_valid);

  // R4: no strobe, no movement
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !smp_en |=> $stable(y_out) && !y_valid);

  // R5: a valid pulse always follows a strobe
  a_r5_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
    y_valid |-> $past(smp_en));

endmodule

// File: tb/tb_symfir_top.sv
module tb_symfir_top;
  import symfir_pkg::*;

  localparam int NI = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b0;
  logic [7:0] din = '0;
  logic signed [19:0] yo [NI];
  logic vo [NI];

  int checks = 0;
  int errors = 0;
  int xs [0:1023];
  int nsmp = 0;
  int ylast [NI];
  string tag = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  symfir_top #(.DW(8), .CW(8), .TAPS(5), .MODE(FOLD_SUM),
               .COEFS({8'h09, 8'h7F, 8'h80})) dut (
    .clk(clk), .rst(rst), .smp_en(en), .smp_in(din), .y_out(yo[0]), .y_valid(vo[0]));

  symfir_top #(.DW(8), .CW(8), .TAPS(6), .MODE(FOLD_DIFF),
               .COEFS({8'h05, 8'h80, 8'h7F})) dut_even (
    .clk(clk), .rst(rst), .smp_en(en), .smp_in(din), .y_out(yo[1]), .y_valid(vo[1]));

  symfir_top #(.DW(8), .CW(8), .TAPS(5), .MODE(FOLD_DIFF),
               .COEFS({8'h33, 8'hF0, 8'h0B})) dut_odd (
    .clk(clk), .rst(rst), .smp_en(en), .smp_in(din), .y_out(yo[2]), .y_valid(vo[2]));

  function automatic int hfull(input int inst, input int k);
    int h [3];
    int n;
    bit anti;
    case (inst)
      0:       begin h = '{-128, 127, 9}; n = 5; anti = 0; end
      1:       begin h = '{127, -128, 5}; n = 6; anti = 1; end
      default: begin h = '{11, -16, 51};  n = 5; anti = 1; end
    endcase
    if (k < 0 || k >= n) return 0;
    if (2*k + 1 == n)    return anti ? 0 : h[k];
    if (k < (n+1)/2)     return h[k];
    return anti ? -h[n-1-k] : h[n-1-k];
  endfunction

  function automatic int expect_y(input int inst, input int idx);
    int s;
    s = 0;
    for (int k = 0; k < 6; k++)
      if (idx - k >= 0) s += hfull(inst, k) * xs[idx-k];
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_outs();
    for (int i = 0; i < NI; i++) begin
      bit ev;
      ev = (nsmp >= 3);
      chk(vo[i] == ev, "R5", $sformatf("valid inst%0d", i), int'(vo[i]), int'(ev));
      if (ev) begin
        int e;
        string r;
        e = expect_y(i, nsmp - 3);
        r = (tag == "R1" && i != 0) ? "R2" : tag;
        chk(int'(yo[i]) == e, r, $sformatf("y inst%0d sample%0d", i, nsmp - 3),
            int'(yo[i]), e);
      end
      ylast[i] = int'(yo[i]);
    end
  endtask

  task automatic strobe(input int v);
    @(negedge clk);
    en  = 1'b1;
    din = v[7:0];
    @(negedge clk);
    en  = 1'b0;
    xs[nsmp] = v;
    nsmp++;
    check_outs();
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      for (int i = 0; i < NI; i++) begin
        chk(vo[i] == 1'b0, "R4", $sformatf("idle valid inst%0d", i), int'(vo[i]), 0);
        chk(int'(yo[i]) == ylast[i], "R4", $sformatf("idle hold inst%0d", i),
            int'(yo[i]), ylast[i]);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    en  = 1'b0;
    repeat (2) @(negedge clk);
    rst  = 1'b0;
    nsmp = 0;
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      chk(int'(yo[i]) == 0, "R7", $sformatf("reset y inst%0d", i), int'(yo[i]), 0);
      chk(vo[i] == 1'b0, "R7", $sformatf("reset valid inst%0d", i), int'(vo[i]), 0);
      ylast[i] = int'(yo[i]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R3: impulse reproduces the coefficient sequence in tap order
    tag = "R3";
    strobe(1);
    for (int j = 0; j < 8; j++) begin
      strobe(0);
      idle(j % 3);
    end

    // R1 / R2: every 8-bit input value, with irregular idle gaps (R4)
    tag = "R1";
    for (int v = -128; v < 128; v++) begin
      strobe(v);
      idle((v + 128) % 3);
    end

    // R6: runs of extreme values against extreme coefficients
    tag = "R6";
    for (int j = 0; j < 8; j++) strobe(-128);
    for (int j = 0; j < 8; j++) strobe(127);
    for (int j = 0; j < 12; j++) strobe((j % 2 == 0) ? -128 : 127);
    for (int j = 0; j < 6; j++) strobe(((j / 2) % 2 == 0) ? 127 : -128);
    idle(50);

    // R7: reset in mid-stream forgets history
    do_reset();
    tag = "R7";
    strobe(1);
    for (int j = 0; j < 7; j++) strobe(0);
    for (int j = 0; j < 20; j++) strobe((j * 37 + 11) % 256 - 128);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule